// File: doc/BRIEF.md
# Secure Boot Partition Access Gate

This block sits between the CPU, the external debug port and the flash controller. It decides, on every request, whether an access may go ahead. The block guards two address windows. The first holds the boot partition that carries the root of trust. The second is a key and configuration store used by later boot stages. Boot firmware writes a small control register before it hands control to application code. Once set, the lock bits in that register hold until the next reset, so later code cannot undo them.

A CPU request reaches memory only when the gate grants it. A refused read returns zeros to the CPU and a refused write never reaches the array. External debug reaches the boot window only when the secure-debug input and the external-access bit permit it, and it may always reach the key window. A chip-erase command wipes the main array and the key window but never touches the boot partition. Any refused access raises a one-cycle violation pulse and sets a sticky status flag, which software clears by writing one to it.

Top module: `boot_gate`

## Requirements
- R1: A CPU request whose address lies in the boot window is refused whenever the lock bit (control bit 1) or the done bit (control bit 2) is 1.
- R2: While neither lock nor done is set, a CPU request to the boot window is granted only when cpu_priv_i is 1. A request outside both windows is always granted.
- R3: A CPU request to the key window is granted only when cpu_priv_i is 1 and the key-disable bit (control bit 3) is 0.
- R4: The register selected by reg_sel_i=0 is the control register: bit 0 ext-access, bit 1 lock, bit 2 done, bit 3 key-disable, with all other bits reading zero. reg_sel_i=1 selects the status register, whose bit 0 is the violation flag. Both registers read zero after reset.
- R5: Lock, done and key-disable are set by writing 1. Writing 0 to them is ignored, and only reset clears them. The ext-access bit follows every write.
- R6: A debug request to the boot window is refused exactly when secure_dbg_en_i is 1 and ext-access is 0.
- R7: A debug request outside the boot window, the key window included, is always granted.
- R8: While erase_req_i is 1, erase_main_o and erase_key_o are 1 in the same cycle. No output erases the boot partition.
- R9: For a refused CPU request, cpu_rdata_o is zero and mem_req_o and mem_we_o stay low. For a granted request, cpu_rdata_o equals mem_rdata_i and mem_we_o equals cpu_we_i.
- R10: A refused CPU or debug request in a cycle drives viol_o high for exactly the following cycle and sets the status flag. A granted request does not raise viol_o.
- R11: Writing 1 to status bit 0 clears the flag. If a new refusal occurs in the same cycle, the flag stays set.
- R12: Window bounds are inclusive: an address hits a window when it is at or above the base and at or below the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| secure_dbg_en_i | input | 1 | Secure debug enabled |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects control, 1 selects status |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data for the selected register |
| cpu_req_i | input | 1 | CPU access request |
| cpu_we_i | input | 1 | CPU write (1) or read (0) |
| cpu_priv_i | input | 1 | Request comes from privileged boot code |
| cpu_addr_i | input | AW | CPU address |
| cpu_gnt_o | output | 1 | CPU access granted |
| cpu_rdata_o | output | DW | Read data returned to the CPU |
| mem_req_o | output | 1 | Request forwarded to flash |
| mem_we_o | output | 1 | Write forwarded to flash |
| mem_rdata_i | input | DW | Read data from flash |
| dbg_req_i | input | 1 | External debug access request |
| dbg_addr_i | input | AW | Debug address |
| dbg_gnt_o | output | 1 | Debug access granted |
| erase_req_i | input | 1 | Chip-erase command |
| erase_main_o | output | 1 | Erase main array |
| erase_key_o | output | 1 | Erase key window |
| viol_o | output | 1 | One-cycle pulse after a refused access |

## Verification
The bench builds the gate with an 8-bit address, a boot window of 0x10 to 0x2F and a key window of 0x40 to 0x4F. With these values, every address can be swept. The sweep covers all sixteen control settings, both privilege levels, reads and writes, and both secure-debug settings. Each window edge and its outer neighbour therefore appear under every combination of lock bits. Directed sequences then cover the stickiness of the lock bits, the violation pulse timing, and the same-cycle race between a clear and a new refusal.

// File: rtl/boot_gate_pkg.sv
package boot_gate_pkg;

  typedef struct packed {
    logic key_off;
    logic done;
    logic lock;
    logic ext_ok;
  } gate_ctrl_t;

  localparam int unsigned CTRL_W    = 4;
  localparam int unsigned PORT_CPU  = 0;
  localparam int unsigned PORT_DBG  = 1;
  localparam int unsigned NUM_PORTS = 2;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_STAT = 1'b1
  } reg_sel_e;

endpackage

// File: rtl/bg_range_dec.sv
module bg_range_dec #(
  parameter int unsigned    AW    = 16,
  parameter logic [AW-1:0]  BASE  = 'h0100,
  parameter logic [AW-1:0]  LIMIT = 'h0FFF
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  assign hit_o = (addr_i >= BASE) && (addr_i <= LIMIT);
endmodule

// File: rtl/bg_ctrl_regs.sv
module bg_ctrl_regs
  import boot_gate_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          viol_set_i,
  output gate_ctrl_t    ctrl_o,
  output logic          viol_flag_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned PAD_CTRL = DW - CTRL_W;
  localparam int unsigned PAD_STAT = DW - 1;

  gate_ctrl_t ctrl_q;
  logic       flag_q;
  logic       ctrl_we, stat_we;
  logic       unused_wdata;

  assign ctrl_we      = we_i && (sel_i == REG_CTRL);
  assign stat_we      = we_i && (sel_i == REG_STAT);
  assign unused_wdata = ^wdata_i[DW-1:CTRL_W];

  // sticky bits only move 0 -> 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q.ext_ok  <= wdata_i[0];
      ctrl_q.lock    <= ctrl_q.lock    | wdata_i[1];
      ctrl_q.done    <= ctrl_q.done    | wdata_i[2];
      ctrl_q.key_off <= ctrl_q.key_off | wdata_i[3];
    end
  end

  // set has priority over w1c
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= viol_set_i | (flag_q & ~(stat_we & wdata_i[0]));
  end

  always_comb begin
    if (sel_i == REG_CTRL) rdata_o = {{PAD_CTRL{1'b0}}, ctrl_q};
    else                   rdata_o = {{PAD_STAT{1'b0}}, flag_q};
  end

  assign ctrl_o      = ctrl_q;
  assign viol_flag_o = flag_q;
endmodule

// File: rtl/bg_policy.sv
module bg_policy
  import boot_gate_pkg::*;
(
  input  gate_ctrl_t ctrl_i,
  input  logic       secure_dbg_en_i,
  input  logic       cpu_req_i,
  input  logic       cpu_priv_i,
  input  logic       cpu_boot_hit_i,
  input  logic       cpu_key_hit_i,
  input  logic       dbg_req_i,
  input  logic       dbg_boot_hit_i,
  output logic       cpu_gnt_o,
  output logic       dbg_gnt_o,
  output logic       blocked_o
);
  logic boot_closed, cpu_ok, dbg_ok;

  assign boot_closed = ctrl_i.lock | ctrl_i.done;

  always_comb begin
    if (cpu_boot_hit_i)     cpu_ok = cpu_priv_i & ~boot_closed;
    else if (cpu_key_hit_i) cpu_ok = cpu_priv_i & ~ctrl_i.key_off;
    else                    cpu_ok = 1'b1;
  end

  // debug is shut out of the boot window only with secure debug on and external access off
  assign dbg_ok = ~(dbg_boot_hit_i & secure_dbg_en_i & ~ctrl_i.ext_ok);

  assign cpu_gnt_o = cpu_req_i & cpu_ok;
  assign dbg_gnt_o = dbg_req_i & dbg_ok;
  assign blocked_o = (cpu_req_i & ~cpu_ok) | (dbg_req_i & ~dbg_ok);
endmodule

// File: rtl/bg_viol.sv
module bg_viol (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic blocked_i,
  output logic viol_o
);
  logic viol_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= blocked_i;
  end
  assign viol_o = viol_q;
endmodule

// File: rtl/boot_gate.sv
module boot_gate
  import boot_gate_pkg::*;
#(
  parameter int unsigned   AW         = 16,
  parameter int unsigned   DW         = 32,
  parameter logic [AW-1:0] BOOT_BASE  = 'h0100,
  parameter logic [AW-1:0] BOOT_LIMIT = 'h0FFF,
  parameter logic [AW-1:0] KEY_BASE   = 'h1000,
  parameter logic [AW-1:0] KEY_LIMIT  = 'h10FF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          secure_dbg_en_i,
  input  logic          reg_we_i,
  input  logic          reg_sel_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic          cpu_priv_i,
  input  logic [AW-1:0] cpu_addr_i,
  output logic          cpu_gnt_o,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          dbg_req_i,
  input  logic [AW-1:0] dbg_addr_i,
  output logic          dbg_gnt_o,
  input  logic          erase_req_i,
  output logic          erase_main_o,
  output logic          erase_key_o,
  output logic          viol_o
);
  gate_ctrl_t           ctrl;
  logic                 viol_flag;
  logic                 blocked;
  logic                 cpu_key_hit;
  logic [NUM_PORTS-1:0] boot_hit;
  logic [AW-1:0]        port_addr [NUM_PORTS];

  assign port_addr[PORT_CPU] = cpu_addr_i;
  assign port_addr[PORT_DBG] = dbg_addr_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_boot_dec
    bg_range_dec #(.AW(AW), .BASE(BOOT_BASE), .LIMIT(BOOT_LIMIT)) u_dec (
      .addr_i (port_addr[p]),
      .hit_o  (boot_hit[p])
    );
  end

  bg_range_dec #(.AW(AW), .BASE(KEY_BASE), .LIMIT(KEY_LIMIT)) u_key_dec (
    .addr_i (cpu_addr_i),
    .hit_o  (cpu_key_hit)
  );

  bg_ctrl_regs #(.DW(DW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .sel_i       (reg_sel_i),
    .wdata_i     (reg_wdata_i),
    .viol_set_i  (blocked),
    .ctrl_o      (ctrl),
    .viol_flag_o (viol_flag),
    .rdata_o     (reg_rdata_o)
  );

  bg_policy u_policy (
    .ctrl_i          (ctrl),
    .secure_dbg_en_i (secure_dbg_en_i),
    .cpu_req_i       (cpu_req_i),
    .cpu_priv_i      (cpu_priv_i),
    .cpu_boot_hit_i  (boot_hit[PORT_CPU]),
    .cpu_key_hit_i   (cpu_key_hit),
    .dbg_req_i       (dbg_req_i),
    .dbg_boot_hit_i  (boot_hit[PORT_DBG]),
    .cpu_gnt_o       (cpu_gnt_o),
    .dbg_gnt_o       (dbg_gnt_o),
    .blocked_o       (blocked)
  );

  bg_viol u_viol (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .blocked_i (blocked),
    .viol_o    (viol_o)
  );

  assign mem_req_o   = cpu_gnt_o;
  assign mem_we_o    = cpu_gnt_o & cpu_we_i;
  assign cpu_rdata_o = cpu_gnt_o ? mem_rdata_i : '0;

  // boot partition has no erase line at all
  assign erase_main_o = erase_req_i;
  assign erase_key_o  = erase_req_i;
endmodule

// File: rtl/bg_checker.sv
module bg_checker
  import boot_gate_pkg::*;
#(
  parameter int unsigned   AW         = 16,
  parameter int unsigned   DW         = 32,
  parameter logic [AW-1:0] BOOT_BASE  = 'h0100,
  parameter logic [AW-1:0] BOOT_LIMIT = 'h0FFF,
  parameter logic [AW-1:0] KEY_BASE   = 'h1000,
  parameter logic [AW-1:0] KEY_LIMIT  = 'h10FF
) (
  input logic          clk_i,
  input logic          rst_ni,
  input gate_ctrl_t    ctrl_i,
  input logic          secure_dbg_en_i,
  input logic          cpu_req_i,
  input logic [AW-1:0] cpu_addr_i,
  input logic          cpu_gnt_o,
  input logic [DW-1:0] cpu_rdata_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          dbg_req_i,
  input logic [AW-1:0] dbg_addr_i,
  input logic          dbg_gnt_o,
  input logic          erase_req_i,
  input logic          erase_main_o,
  input logic          erase_key_o,
  input logic          viol_o
);
  logic cpu_in_boot, cpu_in_key, dbg_in_boot;
  assign cpu_in_boot = (cpu_addr_i >= BOOT_BASE) && (cpu_addr_i <= BOOT_LIMIT);
  assign cpu_in_key  = (cpu_addr_i >= KEY_BASE)  && (cpu_addr_i <= KEY_LIMIT);
  assign dbg_in_boot = (dbg_addr_i >= BOOT_BASE) && (dbg_addr_i <= BOOT_LIMIT);

  // R1
  lock_blocks_boot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_in_boot && (ctrl_i.lock || ctrl_i.done)) |-> !cpu_gnt_o);

  // R3
  key_off_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_in_key && ctrl_i.key_off) |-> !cpu_gnt_o);

  // R5
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.lock |=> ctrl_i.lock);

  // R5
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.done |=> ctrl_i.done);

  // R5
  key_off_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.key_off |=> ctrl_i.key_off);

  // R6
  dbg_boot_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_req_i && dbg_in_boot && secure_dbg_en_i && !ctrl_i.ext_ok) |-> !dbg_gnt_o);

  // R7
  dbg_outside_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_req_i && !dbg_in_boot) |-> dbg_gnt_o);

  // R8
  erase_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_i |-> (erase_main_o && erase_key_o));

  // R9
  blocked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !cpu_gnt_o) |-> (cpu_rdata_o == '0 && !mem_req_o && !mem_we_o));

  // R10
  viol_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cpu_req_i && !cpu_gnt_o) || (dbg_req_i && !dbg_gnt_o)) |=> viol_o);
endmodule

bind boot_gate bg_checker #(
  .AW(AW), .DW(DW),
  .BOOT_BASE(BOOT_BASE), .BOOT_LIMIT(BOOT_LIMIT),
  .KEY_BASE(KEY_BASE), .KEY_LIMIT(KEY_LIMIT)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .ctrl_i          (ctrl),
  .secure_dbg_en_i (secure_dbg_en_i),
  .cpu_req_i       (cpu_req_i),
  .cpu_addr_i      (cpu_addr_i),
  .cpu_gnt_o       (cpu_gnt_o),
  .cpu_rdata_o     (cpu_rdata_o),
  .mem_req_o       (mem_req_o),
  .mem_we_o        (mem_we_o),
  .dbg_req_i       (dbg_req_i),
  .dbg_addr_i      (dbg_addr_i),
  .dbg_gnt_o       (dbg_gnt_o),
  .erase_req_i     (erase_req_i),
  .erase_main_o    (erase_main_o),
  .erase_key_o     (erase_key_o),
  .viol_o          (viol_o)
);

// File: tb/sim_boot_gate.sv
module sim_boot_gate;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;
  localparam logic [AW-1:0] BB = 8'h10, BL = 8'h2F, KB = 8'h40, KL = 8'h4F;
  localparam logic [DW-1:0] MEMV = 32'hA5A5_A5A5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          sde, reg_we, reg_sel;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic          cpu_req, cpu_we, cpu_priv;
  logic [AW-1:0] cpu_addr;
  logic          cpu_gnt;
  logic [DW-1:0] cpu_rdata;
  logic          mem_req, mem_we;
  logic          dbg_req;
  logic [AW-1:0] dbg_addr;
  logic          dbg_gnt;
  logic          erase_req, erase_main, erase_key, viol;

  boot_gate #(.AW(AW), .DW(DW), .BOOT_BASE(BB), .BOOT_LIMIT(BL),
              .KEY_BASE(KB), .KEY_LIMIT(KL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .secure_dbg_en_i(sde),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_priv_i(cpu_priv), .cpu_addr_i(cpu_addr),
    .cpu_gnt_o(cpu_gnt), .cpu_rdata_o(cpu_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_rdata_i(MEMV),
    .dbg_req_i(dbg_req), .dbg_addr_i(dbg_addr), .dbg_gnt_o(dbg_gnt),
    .erase_req_i(erase_req), .erase_main_o(erase_main), .erase_key_o(erase_key),
    .viol_o(viol)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_we = 0; reg_sel = 0; reg_wdata = '0;
    cpu_req = 0; cpu_we = 0; cpu_priv = 0; cpu_addr = '0;
    dbg_req = 0; dbg_addr = '0; erase_req = 0; sde = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic sel, input logic [DW-1:0] data);
    reg_we = 1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 0; reg_wdata = '0;
  endtask

  task automatic reg_rd(input logic sel, output logic [DW-1:0] data);
    reg_sel = sel;
    #1;
    data = reg_rdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] rd;
    do_reset();

    // R4 reset values
    reg_rd(1'b0, rd); chk("R4 ctrl reset", rd, '0);
    reg_rd(1'b1, rd); chk("R4 stat reset", rd, '0);

    // R5 sticky bits
    @(negedge clk);
    reg_wr(1'b0, 32'hFFFF_FFFF);
    reg_rd(1'b0, rd); chk("R4 ctrl all set", rd, 32'h0000_000F);
    @(negedge clk);
    reg_wr(1'b0, 32'h0);
    reg_rd(1'b0, rd); chk("R5 clear ignored", rd, 32'h0000_000E);
    do_reset();
    reg_rd(1'b0, rd); chk("R5 reset clears", rd, '0);

    // exhaustive sweep: ctrl x addr x priv x we, debug x sde
    for (int cfg = 0; cfg < 16; cfg++) begin
      do_reset();
      reg_wr(1'b0, DW'(cfg));
      @(negedge clk);
      #1;
      for (int a = 0; a < 256; a++) begin
        logic in_b, in_k, edge_a, lk, dn, ko, ext, ok;
        string tag;
        in_b   = (a >= BB) && (a <= BL);
        in_k   = (a >= KB) && (a <= KL);
        edge_a = (a == BB) || (a == BL) || (a == KB) || (a == KL) ||
                 (a == BB - 1) || (a == BL + 1) || (a == KB - 1) || (a == KL + 1);
        ext = cfg[0]; lk = cfg[1]; dn = cfg[2]; ko = cfg[3];
        for (int pv = 0; pv < 2; pv++) begin
          for (int w = 0; w < 2; w++) begin
            cpu_req = 1; cpu_addr = AW'(a); cpu_priv = pv[0]; cpu_we = w[0];
            #2;
            if (in_b)      ok = pv[0] && !lk && !dn;
            else if (in_k) ok = pv[0] && !ko;
            else           ok = 1'b1;
            if (edge_a)            tag = "R12 edge gnt";
            else if (in_b && (lk || dn)) tag = "R1 boot gnt";
            else if (in_k)         tag = "R3 key gnt";
            else                   tag = "R2 gnt";
            chk(tag, DW'(cpu_gnt), DW'(ok));
            chk("R9 mem_req", DW'(mem_req), DW'(ok));
            chk("R9 mem_we", DW'(mem_we), DW'(ok && w[0]));
            chk("R9 rdata", cpu_rdata, ok ? MEMV : '0);
          end
        end
        cpu_req = 0;
        for (int s = 0; s < 2; s++) begin
          dbg_req = 1; dbg_addr = AW'(a); sde = s[0];
          #2;
          ok = !(in_b && s[0] && !ext);
          if (in_b) chk("R6 dbg gnt", DW'(dbg_gnt), DW'(ok));
          else      chk("R7 dbg gnt", DW'(dbg_gnt), DW'(ok));
        end
        dbg_req = 0; sde = 0;
      end
    end

    // R10 violation pulse timing
    do_reset();
    reg_wr(1'b0, 32'h2);
    cpu_req = 1; cpu_addr = 8'h20; cpu_priv = 1;
    @(negedge clk);
    cpu_req = 0;
    chk("R10 pulse high", DW'(viol), 1);
    @(negedge clk);
    chk("R10 pulse one cycle", DW'(viol), 0);
    reg_rd(1'b1, rd); chk("R10 status set", rd, 1);

    // R10 debug refusal
    sde = 1; dbg_req = 1; dbg_addr = 8'h10;
    @(negedge clk);
    dbg_req = 0;
    chk("R10 dbg pulse", DW'(viol), 1);

    // R10 granted access no pulse
    cpu_req = 1; cpu_addr = 8'h80; cpu_priv = 0;
    @(negedge clk);
    cpu_req = 0;
    chk("R10 no pulse on grant", DW'(viol), 0);

    // R11 w1c
    reg_wr(1'b1, 32'h1);
    reg_rd(1'b1, rd); chk("R11 w1c clears", rd, 0);
    @(negedge clk);
    reg_we = 1; reg_sel = 1; reg_wdata = 32'h1;
    cpu_req = 1; cpu_addr = 8'h2F; cpu_priv = 1;
    @(negedge clk);
    reg_we = 0; reg_wdata = '0; cpu_req = 0;
    reg_rd(1'b1, rd); chk("R11 set wins", rd, 1);

    // R8 erase
    @(negedge clk);
    erase_req = 1; #1;
    chk("R8 erase main", DW'(erase_main), 1);
    chk("R8 erase key", DW'(erase_key), 1);
    erase_req = 0; #1;
    chk("R8 erase idle", DW'({erase_main, erase_key}), 0);

    @(negedge clk);
    finish_run();
  end
endmodule